// File: doc/BRIEF.md
# Endian-Configurable Load/Store Lane Aligner

This block sits between a 32-bit data memory port and a register file. For loads, it takes the fetched memory word, the two low bits of the byte address, the access size and a signed flag. It picks the addressed byte lane or the whole word and extends the result to the full register width. The result is presented, registered, for writeback. For stores, it places the outgoing byte or word into the memory byte lanes and drives one write strobe per lane.

Byte ordering is a configuration choice. A configuration pin is captured on every clock edge while the synchronous reset is held. When reset is released, the captured mode is frozen, and every lane select and every store placement follows it until the next reset. In the memory word, bits 7:0 are the byte at offset 0 and bits 31:24 are the byte at offset 3.

A word access whose offset is not zero is refused. The block raises a one-cycle fault pulse and produces neither a load result nor a memory write.

Top module: `ldst_lane_unit`

## Requirements
- R1: While `rst` is high, the outputs seen after each clock edge are `ld_valid`=0, `wr_en`=0, `wr_strb`=0 and `align_fault`=0, whatever the request inputs are.
- R2: The byte order is loaded from `cfg_big_endian` on every rising edge at which `rst` is high, so the value present on the last reset edge wins. A value of 0 selects little endian and 1 selects big endian.
- R3: After reset is released, changes on `cfg_big_endian` have no effect on any lane selection or store placement.
- R4: For a byte access at offset `a`, the lane is k=a in little-endian mode and k=3-a in big-endian mode, where lane k is bits 8k+7:8k of the memory word.
- R5: An unsigned byte load (`rd_size`=0, `rd_signed`=0) returns the selected byte in bits 7:0, with bits 31:8 cleared.
- R6: A signed byte load (`rd_size`=0, `rd_signed`=1) returns the selected byte in bits 7:0, with bits 31:8 all equal to its bit 7.
- R7: A word load (`rd_size`=1, offset 0) returns the memory word unchanged in little-endian mode, and with its four bytes in reverse order in big-endian mode.
- R8: A byte store (`st_size`=0) drives `st_data[7:0]` into all four lanes of `wr_data` and asserts exactly one strobe, `wr_strb[k]`, for the lane k defined in R4.
- R9: A word store (`st_size`=1, offset 0) asserts all four strobes. It drives `st_data` unchanged in little-endian mode and byte-reversed in big-endian mode.
- R10: A word request of either kind with a nonzero offset raises `align_fault` for exactly one cycle. The refused request produces no `ld_valid` or no `wr_en` respectively.
- R11: Results appear exactly one cycle after the request. `ld_valid` and `wr_en` are high for one cycle per accepted request, and low in cycles with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cfg_big_endian | input | 1 | Byte order request, captured only during reset (1 = big endian) |
| rd_valid | input | 1 | Read response valid this cycle |
| rd_word | input | 32 | Word returned by memory |
| rd_addr_lo | input | 2 | Byte offset of the load address |
| rd_size | input | 1 | Load size: 0 byte, 1 word |
| rd_signed | input | 1 | Sign-extend a byte load when 1 |
| st_valid | input | 1 | Store request valid this cycle |
| st_addr_lo | input | 2 | Byte offset of the store address |
| st_size | input | 1 | Store size: 0 byte, 1 word |
| st_data | input | 32 | Register value to store |
| ld_valid | output | 1 | Registered load result valid |
| ld_data | output | 32 | Aligned and extended load result |
| wr_en | output | 1 | Memory write enable |
| wr_strb | output | 4 | Per-lane write strobes |
| wr_data | output | 32 | Lane-placed store data |
| align_fault | output | 1 | One-cycle pulse for a misaligned word request |

## Verification
The single piece of internal state is the latched byte order. If it is wrong, or if it follows the pin after reset, it shows up on the very next byte access as a byte taken from the mirrored lane, or as a strobe on the mirrored lane. A word access shows it as a reversed word. Stimulus therefore toggles the configuration pin after reset and checks every access against the mode that held on the last reset edge. Errors in the registered path show up one cycle after a request, as a missing or stretched `ld_valid`, `wr_en` or fault pulse.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic {
    SZ_BYTE = 1'b0,
    SZ_WORD = 1'b1
  } acc_size_e;
endpackage

// File: rtl/lsu_order_latch.sv
module lsu_order_latch (
  input  logic clk,
  input  logic rst,
  input  logic cfg_big_i,
  output logic big_o
);
  // Captured on every reset edge; frozen once reset is released.
  always_ff @(posedge clk) begin
    if (rst) big_o <= cfg_big_i;
  end
endmodule

// File: rtl/lsu_load_path.sv
module lsu_load_path
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          big_i,
  input  logic                          req_i,
  input  logic [DATA_W-1:0]             word_i,
  input  logic [$clog2(DATA_W/8)-1:0]   ofs_i,
  input  acc_size_e                     size_i,
  input  logic                          signed_i,
  output logic                          valid_o,
  output logic [DATA_W-1:0]             data_o,
  output logic                          fault_o
);
  localparam int LANES = DATA_W / BYTE_W;
  localparam int OFS_W = $clog2(LANES);
  localparam int EXT_W = DATA_W - BYTE_W;

  logic [LANES-1:0][BYTE_W-1:0] lanes_in;
  logic [DATA_W-1:0]            word_rev;
  logic [OFS_W-1:0]             lane_sel;
  logic [BYTE_W-1:0]            pick;
  logic [DATA_W-1:0]            byte_ext;
  logic [DATA_W-1:0]            word_val;
  logic                         misalign;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lanes_in[g] = word_i[g*BYTE_W +: BYTE_W];
    assign word_rev[g*BYTE_W +: BYTE_W] = word_i[(LANES-1-g)*BYTE_W +: BYTE_W];
  end

  always_comb begin
    lane_sel = big_i ? ~ofs_i : ofs_i;
    pick     = lanes_in[lane_sel];
    byte_ext = signed_i ? {{EXT_W{pick[BYTE_W-1]}}, pick} : {{EXT_W{1'b0}}, pick};
    word_val = big_i ? word_rev : word_i;
    misalign = (size_i == SZ_WORD) && (ofs_i != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      fault_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= req_i && !misalign;
      fault_o <= req_i && misalign;
      if (req_i && !misalign) data_o <= (size_i == SZ_BYTE) ? byte_ext : word_val;
    end
  end
endmodule

// File: rtl/lsu_store_path.sv
module lsu_store_path
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          big_i,
  input  logic                          req_i,
  input  logic [$clog2(DATA_W/8)-1:0]   ofs_i,
  input  acc_size_e                     size_i,
  input  logic [DATA_W-1:0]             data_i,
  output logic                          wen_o,
  output logic [DATA_W/8-1:0]           strb_o,
  output logic [DATA_W-1:0]             data_o,
  output logic                          fault_o
);
  localparam int LANES = DATA_W / BYTE_W;
  localparam int OFS_W = $clog2(LANES);

  logic [DATA_W-1:0] data_rev;
  logic [DATA_W-1:0] byte_rep;
  logic [OFS_W-1:0]  lane_sel;
  logic [LANES-1:0]  strb_nx;
  logic [DATA_W-1:0] data_nx;
  logic              misalign;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign data_rev[g*BYTE_W +: BYTE_W] = data_i[(LANES-1-g)*BYTE_W +: BYTE_W];
    assign byte_rep[g*BYTE_W +: BYTE_W] = data_i[BYTE_W-1:0];
    assign strb_nx[g] = (size_i == SZ_WORD) || (lane_sel == OFS_W'(g));
  end

  always_comb begin
    lane_sel = big_i ? ~ofs_i : ofs_i;
    misalign = (size_i == SZ_WORD) && (ofs_i != '0);
    if (size_i == SZ_BYTE) data_nx = byte_rep;
    else                   data_nx = big_i ? data_rev : data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wen_o   <= 1'b0;
      strb_o  <= '0;
      data_o  <= '0;
      fault_o <= 1'b0;
    end else begin
      wen_o   <= req_i && !misalign;
      fault_o <= req_i && misalign;
      strb_o  <= (req_i && !misalign) ? strb_nx : '0;
      if (req_i && !misalign) data_o <= data_nx;
    end
  end
endmodule

// File: rtl/ldst_lane_unit.sv
module ldst_lane_unit
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cfg_big_endian,
  input  logic                        rd_valid,
  input  logic [DATA_W-1:0]           rd_word,
  input  logic [$clog2(DATA_W/8)-1:0] rd_addr_lo,
  input  logic                        rd_size,
  input  logic                        rd_signed,
  input  logic                        st_valid,
  input  logic [$clog2(DATA_W/8)-1:0] st_addr_lo,
  input  logic                        st_size,
  input  logic [DATA_W-1:0]           st_data,
  output logic                        ld_valid,
  output logic [DATA_W-1:0]           ld_data,
  output logic                        wr_en,
  output logic [DATA_W/8-1:0]         wr_strb,
  output logic [DATA_W-1:0]           wr_data,
  output logic                        align_fault
);
  logic big_q;
  logic ld_fault;
  logic st_fault;

  lsu_order_latch u_order (
    .clk       (clk),
    .rst       (rst),
    .cfg_big_i (cfg_big_endian),
    .big_o     (big_q)
  );

  lsu_load_path #(.DATA_W(DATA_W)) u_load (
    .clk      (clk),
    .rst      (rst),
    .big_i    (big_q),
    .req_i    (rd_valid),
    .word_i   (rd_word),
    .ofs_i    (rd_addr_lo),
    .size_i   (acc_size_e'(rd_size)),
    .signed_i (rd_signed),
    .valid_o  (ld_valid),
    .data_o   (ld_data),
    .fault_o  (ld_fault)
  );

  lsu_store_path #(.DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .big_i   (big_q),
    .req_i   (st_valid),
    .ofs_i   (st_addr_lo),
    .size_i  (acc_size_e'(st_size)),
    .data_i  (st_data),
    .wen_o   (wr_en),
    .strb_o  (wr_strb),
    .data_o  (wr_data),
    .fault_o (st_fault)
  );

  assign align_fault = ld_fault | st_fault;
endmodule

// File: rtl/ldst_lane_checker.sv
module ldst_lane_checker #(
  parameter int DATA_W = 32
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        mode_big,
  input logic                        rd_valid,
  input logic [$clog2(DATA_W/8)-1:0] rd_addr_lo,
  input logic                        rd_size,
  input logic                        rd_signed,
  input logic                        st_valid,
  input logic [$clog2(DATA_W/8)-1:0] st_addr_lo,
  input logic                        st_size,
  input logic                        ld_valid,
  input logic [DATA_W-1:0]           ld_data,
  input logic                        wr_en,
  input logic [DATA_W/8-1:0]         wr_strb,
  input logic [DATA_W-1:0]           wr_data,
  input logic                        align_fault
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!ld_valid && !wr_en && wr_strb == '0 && !align_fault));

  p_mode_frozen_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(mode_big));

  p_zero_ext_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_size && !rd_signed) |=> (ld_data[DATA_W-1:8] == '0));

  p_sign_ext_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_size && rd_signed) |=> (ld_data[DATA_W-1:8] == {(DATA_W-8){ld_data[7]}}));

  p_byte_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    (st_valid && !st_size) |=> (wr_en && $countones(wr_strb) == 1 &&
                                wr_data[15:8] == wr_data[7:0]));

  p_word_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    (st_valid && st_size && st_addr_lo == '0) |=> (wr_en && wr_strb == '1));

  p_st_fault_r10: assert property (@(posedge clk) disable iff (rst)
    (st_valid && st_size && st_addr_lo != '0) |=> (align_fault && !wr_en));

  p_ld_fault_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_size && rd_addr_lo != '0) |=> (align_fault && !ld_valid));

  p_ld_latency_r11: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !(rd_size && rd_addr_lo != '0)) |=> ld_valid);

  p_ld_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |=> !ld_valid);

  p_st_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !st_valid |=> (!wr_en && wr_strb == '0));
endmodule

bind ldst_lane_unit ldst_lane_checker #(.DATA_W(DATA_W)) u_lane_checker (
  .clk         (clk),
  .rst         (rst),
  .mode_big    (big_q),
  .rd_valid    (rd_valid),
  .rd_addr_lo  (rd_addr_lo),
  .rd_size     (rd_size),
  .rd_signed   (rd_signed),
  .st_valid    (st_valid),
  .st_addr_lo  (st_addr_lo),
  .st_size     (st_size),
  .ld_valid    (ld_valid),
  .ld_data     (ld_data),
  .wr_en       (wr_en),
  .wr_strb     (wr_strb),
  .wr_data     (wr_data),
  .align_fault (align_fault)
);

// File: tb/test_ldst_lane_unit.sv
module test_ldst_lane_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_big_endian = 1'b0;
  logic        rd_valid = 1'b0;
  logic [31:0] rd_word = '0;
  logic [1:0]  rd_addr_lo = '0;
  logic        rd_size = 1'b0;
  logic        rd_signed = 1'b0;
  logic        st_valid = 1'b0;
  logic [1:0]  st_addr_lo = '0;
  logic        st_size = 1'b0;
  logic [31:0] st_data = '0;
  logic        ld_valid;
  logic [31:0] ld_data;
  logic        wr_en;
  logic [3:0]  wr_strb;
  logic [31:0] wr_data;
  logic        align_fault;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;
  bit be_model = 1'b0;

  always #4 clk = ~clk;

  ldst_lane_unit i_ldst_lane_unit (
    .clk(clk), .rst(rst), .cfg_big_endian(cfg_big_endian),
    .rd_valid(rd_valid), .rd_word(rd_word), .rd_addr_lo(rd_addr_lo),
    .rd_size(rd_size), .rd_signed(rd_signed),
    .st_valid(st_valid), .st_addr_lo(st_addr_lo), .st_size(st_size),
    .st_data(st_data), .ld_valid(ld_valid), .ld_data(ld_data),
    .wr_en(wr_en), .wr_strb(wr_strb), .wr_data(wr_data),
    .align_fault(align_fault)
  );

  function automatic logic [31:0] rev32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [1:0] lane_of(input logic [1:0] a, input bit be);
    return be ? 2'd3 - a : a;
  endfunction

  function automatic logic [31:0] exp_load(input logic [31:0] w, input logic [1:0] a,
                                           input logic sz, input logic sg, input bit be);
    logic [7:0] b;
    if (sz) return be ? rev32(w) : w;
    case (lane_of(a, be))
      2'd0: b = w[7:0];
      2'd1: b = w[15:8];
      2'd2: b = w[23:16];
      default: b = w[31:24];
    endcase
    return sg ? {{24{b[7]}}, b} : {24'h0, b};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  // Called at a negedge: drive, let one posedge pass, check at the next negedge.
  task automatic apply(input logic rv, input logic [31:0] w, input logic [1:0] ra,
                       input logic rs, input logic rsg, input logic sv,
                       input logic [1:0] sa, input logic ss, input logic [31:0] sd,
                       input string tag);
    bit ld_bad, st_bad, exp_ldv, exp_wen;
    logic [3:0] exp_strb;
    logic [31:0] exp_wd, exp_ld;
    rd_valid = rv; rd_word = w; rd_addr_lo = ra; rd_size = rs; rd_signed = rsg;
    st_valid = sv; st_addr_lo = sa; st_size = ss; st_data = sd;
    @(posedge clk);
    @(negedge clk);
    ld_bad  = rv && rs && (ra != 2'd0);
    st_bad  = sv && ss && (sa != 2'd0);
    exp_ldv = rv && !ld_bad;
    exp_wen = sv && !st_bad;
    exp_ld  = exp_load(w, ra, rs, rsg, be_model);
    if (ss) begin
      exp_strb = 4'hF;
      exp_wd   = be_model ? rev32(sd) : sd;
    end else begin
      exp_strb = 4'b0001 << lane_of(sa, be_model);
      exp_wd   = {4{sd[7:0]}};
    end
    if (!exp_wen) exp_strb = 4'h0;
    check(ld_valid == exp_ldv, {tag, " R11 ld_valid"}, 32'(ld_valid), 32'(exp_ldv));
    check(wr_en == exp_wen, {tag, " R11 wr_en"}, 32'(wr_en), 32'(exp_wen));
    check(align_fault == (ld_bad || st_bad), {tag, " R10 fault"}, 32'(align_fault),
          32'(ld_bad || st_bad));
    check(wr_strb == exp_strb, {tag, ss ? " R9 strb" : " R8 strb"}, 32'(wr_strb),
          32'(exp_strb));
    if (exp_ldv)
      check(ld_data == exp_ld,
            {tag, rs ? " R7 word load" : (rsg ? " R6 R4 signed byte" : " R5 R4 unsigned byte")},
            ld_data, exp_ld);
    if (exp_wen)
      check(wr_data == exp_wd, {tag, ss ? " R9 word store" : " R8 byte store"},
            wr_data, exp_wd);
  endtask

  task automatic idle(input string tag);
    apply(1'b0, 32'h0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0, tag);
  endtask

  // Holds reset for several edges; the cfg value on the last edge is final_cfg.
  task automatic do_reset(input bit early_cfg, input bit final_cfg);
    @(negedge clk);
    rst = 1'b1; cfg_big_endian = early_cfg;
    rd_valid = 1'b1; st_valid = 1'b1; st_size = 1'b0; rd_size = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!ld_valid && !wr_en && wr_strb == 4'h0 && !align_fault, "R1 reset outputs",
          {28'h0, ld_valid, wr_en, align_fault, |wr_strb}, 32'h0);
    cfg_big_endian = final_cfg;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0; rd_valid = 1'b0; st_valid = 1'b0;
    be_model = final_cfg;
  endtask

  task automatic random_phase(input int n, input bit toggle_cfg, input string tag);
    for (int i = 0; i < n; i++) begin
      logic [1:0] ra, sa;
      logic rs, ss;
      ra = 2'($urandom_range(0, 3));
      sa = 2'($urandom_range(0, 3));
      rs = ($urandom_range(0, 3) == 0);
      ss = ($urandom_range(0, 3) == 0);
      if (toggle_cfg) cfg_big_endian = 1'($urandom);
      apply(1'($urandom), $urandom, ra, rs, 1'($urandom), 1'($urandom), sa, ss,
            $urandom, tag);
    end
  endtask

  initial begin
    #(8 * 150000);
    n_fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1357));
    // R2: little endian selected when the pin is low on the last reset edge
    do_reset(1'b1, 1'b0);
    apply(1'b1, 32'h8899AABB, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0, "R2 le");
    apply(1'b1, 32'h8899AABB, 2'd3, 1'b0, 1'b1, 1'b1, 2'd2, 1'b0, 32'h000000C5, "R4 le");
    apply(1'b1, 32'h7F000080, 2'd0, 1'b0, 1'b1, 1'b1, 2'd0, 1'b1, 32'h01020304, "R6 neg");
    apply(1'b1, 32'h11223344, 2'd1, 1'b1, 1'b0, 1'b1, 2'd3, 1'b1, 32'h0, "R10 both");
    idle("R11 after fault");
    random_phase(400, 1'b0, "rand-le");
    // R3: mode held little endian while the pin toggles
    cfg_big_endian = 1'b1;
    apply(1'b1, 32'h11223344, 2'd0, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 32'h000000AB, "R3 pin high");
    random_phase(300, 1'b1, "R3 rand-le");
    // R2: big endian captured from the last reset edge
    do_reset(1'b0, 1'b1);
    apply(1'b1, 32'h8899AABB, 2'd0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 32'h0000005A, "R2 be");
    apply(1'b1, 32'h11223344, 2'd0, 1'b1, 1'b0, 1'b1, 2'd0, 1'b1, 32'hA1B2C3D4, "R7 R9 be");
    apply(1'b1, 32'h00800000, 2'd1, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 32'h0, "R6 be");
    cfg_big_endian = 1'b0;
    apply(1'b1, 32'h8899AABB, 2'd3, 1'b0, 1'b0, 1'b1, 2'd3, 1'b0, 32'h00000077, "R3 pin low");
    random_phase(600, 1'b1, "R3 rand-be");
    apply(1'b0, 32'h0, 2'd0, 1'b0, 1'b0, 1'b1, 2'd2, 1'b1, 32'h0, "R10 st only");
    idle("R11 idle");
    finish_run();
  end
endmodule